// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side serial interface of a small NOR-flash model. It oversamples chip select, serial clock and serial data-in on the system clock, collects a one-byte command followed by any address or data bytes, and carries out the register and read commands itself. Status reads and array reads are shifted out on the serial data-out pin, with a separate output-enable standing in for a tri-state driver.

Erase, page-program and status-write commands are not executed here. They are forwarded as a one-cycle request to an array-write unit, whose busy flag the block observes. That unit also writes the byte array through a plain write port. A low-power sleep state can be entered and left by command.

Top module: `spi_flash_front`

## Requirements
- R1: After reset the output-enable and the write request are low, and a status read returns 0x00.
- R2: Command 0x06 sets the write-enable flag and 0x04 clears it. Either takes effect only when chip select rises on a byte boundary after the full command byte. A command cut short (7 bits) or followed by stray bits (12 bits) changes nothing.
- R3: Command 0x05 shifts out the status byte MSB first: bit 0 is the write-unit busy flag, bit 1 is the write-enable flag, bits 7..2 are zero. The byte repeats for as long as chip select stays low.
- R4: Command 0x03 takes three address bytes, most significant first. Data bytes then follow MSB first from array entry (address mod DEPTH). Input bits are taken on rising clock edges, and data-out changes only after falling clock edges.
- R5: The read address increments after each byte and wraps from DEPTH-1 to 0, so a read can run indefinitely.
- R6: The output-enable is low whenever chip select is high or no output phase is active, including while command and address bits are shifting in. It drops within 3 system clocks of chip select rising, which ends a read at any point.
- R7: A read command received while the write unit is busy is refused: the output-enable stays low and no write request is issued.
- R8: With the write-enable flag set, the write unit idle and chip select rising on a byte boundary, these commands issue a single-cycle write request and clear the flag:
  - page program (0x02) after 3 address bytes, kind 0;
  - sector erase (0xD8) after 3 address bytes, kind 1 with that address;
  - bulk erase (0xC7), kind 2 with address 0;
  - status write (0x01) after 1 byte, kind 3 with that byte on the data output.
  Without the flag, or while the unit is busy, no request is issued.
- R9: Command 0xB9 enters sleep. In sleep every command except 0xAB is ignored (no output, no flag change). Command 0xAB returns the block to active mode.
- R10: Clock polarity idle-high with rising-edge capture (mode 3) gives the same results as idle-low (mode 0).
- R11: A pulse on the array write strobe stores the write data at the write address, and a later read returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Data-out enable, low means high impedance |
| wr_busy | input | 1 | Write unit has a cycle in progress |
| wr_req | output | 1 | One-cycle write request to the write unit |
| wr_kind | output | 2 | Request kind: 0 page program, 1 sector erase, 2 bulk erase, 3 status write |
| wr_addr | output | 24 | Address for the request |
| wr_data | output | 8 | First byte after the command (status write value) |
| arr_we | input | 1 | Array byte write strobe from the write unit |
| arr_waddr | input | AW | Array byte write address, AW = log2(DEPTH) |
| arr_wdata | input | 8 | Array byte write data |

## Verification
Every serial pin passes a two-stage synchronizer and then one engine register. A data-out bit therefore changes 3 system clocks after the serial clock falls. The output-enable drops, and a write request pulses, 3 clocks after chip select rises. The bench holds each serial clock half-period for 6 system clocks and samples data-out just before each rising edge. It also waits 6 clocks after chip select rises before it inspects the output-enable or the latched request, so every result is due before it is read.

// File: rtl/sfl_pkg.sv
// Shared command codes and enumerations for the serial flash front-end.
package sfl_pkg;

    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_WR_DIS     = 8'h04;
    localparam logic [7:0] OPC_STAT_RD    = 8'h05;
    localparam logic [7:0] OPC_STAT_WR    = 8'h01;
    localparam logic [7:0] OPC_READ       = 8'h03;
    localparam logic [7:0] OPC_PROG       = 8'h02;
    localparam logic [7:0] OPC_SECT_ERASE = 8'hD8;
    localparam logic [7:0] OPC_BULK_ERASE = 8'hC7;
    localparam logic [7:0] OPC_SLEEP      = 8'hB9;
    localparam logic [7:0] OPC_WAKE       = 8'hAB;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_STAT = 2'd1,
        OUT_ARR  = 2'd2
    } out_mode_e;

    typedef enum logic [1:0] {
        WK_PAGE   = 2'd0,
        WK_SECTOR = 2'd1,
        WK_BULK   = 2'd2,
        WK_STATUS = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/sfl_pin_sync.sv
// Synchronizes the three serial pins into the system clock domain and
// derives serial clock edge strobes plus a chip-select rise strobe.
// Assumes the system clock runs several times faster than the serial clock.
module sfl_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_o,
    output logic cs_rise_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic mosi_o
);

    logic [2:0] chain [STAGES];
    logic       cs_prev;
    logic       sck_prev;

    // Synchronizer chain; bit 2 chip select, bit 1 clock, bit 0 data.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 3'b101;
                else if (g == 0) chain[g] <= {cs_n_i, sck_i, mosi_i};
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= chain[STAGES-1][2];
            sck_prev <= chain[STAGES-1][1];
        end
    end

    assign cs_o       = chain[STAGES-1][2];
    assign mosi_o     = chain[STAGES-1][0];
    assign cs_rise_o  = chain[STAGES-1][2] & ~cs_prev;
    assign sck_rise_o = chain[STAGES-1][1] & ~sck_prev;
    assign sck_fall_o = ~chain[STAGES-1][1] & sck_prev;

endmodule

// File: rtl/sfl_array.sv
// Byte-wide register array. Reset loads a computed pattern; the write unit
// stores bytes through one write port; reads are combinational.
module sfl_array #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Reset pattern load and byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 37 + 90);
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sfl_cmd_engine.sv
// Command engine: shifts in command and address bytes, runs the flag,
// status-read, array-read and sleep commands, and forwards write-type
// commands as one-cycle requests. Commits happen at chip-select rise.
// Assumes strobes come from sfl_pin_sync, one cycle wide each.
module sfl_cmd_engine
    import sfl_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          cs_rise,
    input  logic          rise,
    input  logic          fall,
    input  logic          mosi_s,
    input  logic          wr_busy,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_idx,
    output logic          miso,
    output logic          oe,
    output logic          wr_req,
    output logic [1:0]    wr_kind,
    output logic [23:0]   wr_addr,
    output logic [7:0]    wr_data,
    output logic          wel_o,
    output logic          dpd_o
);

    logic [6:0]    sh_q;
    logic [2:0]    bitcnt_q;
    logic [7:0]    op_q;
    logic          op_ok_q;
    logic          op_blk_q;
    logic [2:0]    nb_q;
    logic [23:0]   addr_q;
    logic [7:0]    data0_q;
    out_mode_e     outm_q;
    logic [7:0]    out_sh_q;
    logic [2:0]    obit_q;
    logic [AW-1:0] ptr_q;
    logic          miso_q, oe_q, wel_q, dpd_q;
    logic          req_q;
    wr_kind_e      kind_q, kind_n;
    logic [23:0]   req_addr_q;
    logic [7:0]    req_data_q;
    logic          req_ok;

    logic [7:0]  byte_in;
    logic [23:0] addr_next;
    logic [7:0]  status;

    assign byte_in   = {sh_q, mosi_s};
    assign addr_next = {addr_q[15:0], byte_in};
    assign status    = {6'd0, wel_q, wr_busy};
    assign rd_idx    = (outm_q == OUT_ARR) ? ptr_q + AW'(1) : addr_next[AW-1:0];

    // Decide whether the finished command is a complete write-type request.
    always_comb begin
        req_ok = 1'b0;
        kind_n = WK_PAGE;
        case (op_q)
            OPC_PROG:       begin req_ok = (nb_q >= 3'd3); kind_n = WK_PAGE;   end
            OPC_SECT_ERASE: begin req_ok = (nb_q >= 3'd3); kind_n = WK_SECTOR; end
            OPC_BULK_ERASE: begin req_ok = 1'b1;           kind_n = WK_BULK;   end
            OPC_STAT_WR:    begin req_ok = (nb_q >= 3'd1); kind_n = WK_STATUS; end
            default:        begin req_ok = 1'b0;           kind_n = WK_PAGE;   end
        endcase
    end

    // Main sequencer: shift-in, output shift, commit at deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;       bitcnt_q <= '0;   op_q <= '0;
            op_ok_q <= 1'b0;  op_blk_q <= 1'b0; nb_q <= '0;
            addr_q <= '0;     data0_q <= '0;    outm_q <= OUT_NONE;
            out_sh_q <= '0;   obit_q <= '0;     ptr_q <= '0;
            miso_q <= 1'b0;   oe_q <= 1'b0;     wel_q <= 1'b0;
            dpd_q <= 1'b0;    req_q <= 1'b0;    kind_q <= WK_PAGE;
            req_addr_q <= '0; req_data_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (cs_s) begin
                if (cs_rise && op_ok_q && bitcnt_q == 3'd0) begin
                    if (dpd_q) begin
                        if (op_q == OPC_WAKE) dpd_q <= 1'b0;
                    end else if (op_q == OPC_WR_EN) begin
                        wel_q <= 1'b1;
                    end else if (op_q == OPC_WR_DIS) begin
                        wel_q <= 1'b0;
                    end else if (op_q == OPC_SLEEP) begin
                        dpd_q <= 1'b1;
                    end else if (req_ok && wel_q && !wr_busy) begin
                        req_q      <= 1'b1;
                        kind_q     <= kind_n;
                        req_addr_q <= (kind_n == WK_BULK) ? 24'd0 : addr_q;
                        req_data_q <= data0_q;
                        wel_q      <= 1'b0;
                    end
                end
                bitcnt_q <= '0;
                nb_q     <= '0;
                op_ok_q  <= 1'b0;
                outm_q   <= OUT_NONE;
                oe_q     <= 1'b0;
                obit_q   <= '0;
            end else begin
                if (rise) begin
                    sh_q     <= byte_in[6:0];
                    bitcnt_q <= bitcnt_q + 3'd1;
                end
                if (rise && bitcnt_q == 3'd7) begin
                    if (!op_ok_q) begin
                        op_q     <= byte_in;
                        op_ok_q  <= 1'b1;
                        op_blk_q <= wr_busy;
                        if (!dpd_q && byte_in == OPC_STAT_RD) begin
                            outm_q   <= OUT_STAT;
                            out_sh_q <= status;
                        end
                    end else begin
                        if (nb_q < 3'd4) nb_q <= nb_q + 3'd1;
                        if (nb_q < 3'd3) addr_q <= addr_next;
                        if (nb_q == 3'd0) data0_q <= byte_in;
                        if (nb_q == 3'd2 && op_q == OPC_READ && !dpd_q && !op_blk_q) begin
                            outm_q   <= OUT_ARR;
                            ptr_q    <= addr_next[AW-1:0];
                            out_sh_q <= rd_data;
                        end
                    end
                end
                if (fall && outm_q != OUT_NONE) begin
                    oe_q   <= 1'b1;
                    miso_q <= out_sh_q[7];
                    obit_q <= obit_q + 3'd1;
                    if (obit_q == 3'd7) begin
                        if (outm_q == OUT_STAT) begin
                            out_sh_q <= status;
                        end else begin
                            ptr_q    <= ptr_q + AW'(1);
                            out_sh_q <= rd_data;
                        end
                    end else begin
                        out_sh_q <= {out_sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso    = miso_q;
    assign oe      = oe_q;
    assign wr_req  = req_q;
    assign wr_kind = kind_q;
    assign wr_addr = req_addr_q;
    assign wr_data = req_data_q;
    assign wel_o   = wel_q;
    assign dpd_o   = dpd_q;

endmodule

// File: rtl/spi_flash_front.sv
// Top of the serial flash front-end: pin synchronizer, command engine and
// byte array. Assumes clk is at least 4x the serial clock rate.
module spi_flash_front #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    input  logic          wr_busy,
    output logic          wr_req,
    output logic [1:0]    wr_kind,
    output logic [23:0]   wr_addr,
    output logic [7:0]    wr_data,
    input  logic          arr_we,
    input  logic [AW-1:0] arr_waddr,
    input  logic [7:0]    arr_wdata
);

    logic          cs_s, cs_rise, sck_rise, sck_fall, mosi_s;
    logic [AW-1:0] rd_idx;
    logic [7:0]    rd_data;
    logic          wel, dpd;

    sfl_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
        .cs_o(cs_s), .cs_rise_o(cs_rise),
        .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .mosi_o(mosi_s)
    );

    sfl_cmd_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .cs_rise(cs_rise), .rise(sck_rise), .fall(sck_fall),
        .mosi_s(mosi_s), .wr_busy(wr_busy),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .miso(spi_miso), .oe(spi_miso_oe),
        .wr_req(wr_req), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .wel_o(wel), .dpd_o(dpd)
    );

    sfl_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(rd_idx), .rdata(rd_data)
    );

endmodule

// File: rtl/spi_flash_front_chk.sv
// Property checker for spi_flash_front, attached through bind below.
module spi_flash_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sck_fall,
    input logic miso,
    input logic oe,
    input logic wr_req,
    input logic wr_busy,
    input logic wel,
    input logic dpd
);

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !$past(cs_s));                                   // R6
    AST_OE_NOT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !dpd);                                           // R9
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sck_fall));                    // R4
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);                                    // R8
    AST_REQ_IDLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !$past(wr_busy));                            // R8
    AST_REQ_CLEARS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (!wel && $past(wel)));                       // R8

endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_fall(sck_fall),
    .miso(spi_miso), .oe(spi_miso_oe), .wr_req(wr_req),
    .wr_busy(wr_busy), .wel(wel), .dpd(dpd)
);

// File: tb/spi_flash_front_test.sv
// Directed bench: one task per scenario, each checking its own results.
module spi_flash_front_test;

    localparam int CLK_NS = 10;
    localparam int HALF   = 6;
    localparam int DEPTH  = 64;
    localparam int AW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic          miso, oe;
    logic          busy = 1'b0;
    logic          wr_req;
    logic [1:0]    wr_kind;
    logic [23:0]   wr_addr;
    logic [7:0]    wr_data;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [7:0]    wdata = '0;

    int   checks = 0, failures = 0;
    bit   mode3 = 1'b0, done = 1'b0;
    bit   oe_seen = 1'b0;
    int   req_cnt = 0;
    logic [1:0]  lk;
    logic [23:0] la;
    logic [7:0]  ld;
    logic [7:0]  model [DEPTH];

    spi_flash_front #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(oe), .wr_busy(busy),
        .wr_req(wr_req), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_we(we), .arr_waddr(waddr), .arr_wdata(wdata)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (oe) oe_seen <= 1'b1;
        if (wr_req) begin
            req_cnt <= req_cnt + 1;
            lk <= wr_kind; la <= wr_addr; ld <= wr_data;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic sel();
        sck = mode3;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        if (!mode3) begin
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bits(input int n, input logic [7:0] v, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            sck  = 1'b0;
            mosi = v[7-i];
            repeat (HALF) @(negedge clk);
            rx  = {rx[6:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [7:0] v, output logic [7:0] rx);
        bits(8, v, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] rx;
        sel(); xfer(op, rx); desel();
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [7:0] rx;
        sel(); xfer(8'h05, rx); xfer(8'h00, st); desel();
    endtask

    task automatic read_check(input logic [23:0] a, input int n, input string tag);
        logic [7:0] rx;
        sel();
        xfer(8'h03, rx);
        check(oe == 1'b0, "R6 oe low during command", 32'(oe), 0);
        xfer(a[23:16], rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx);
            check(rx == model[(int'(a) + k) % DEPTH], tag, 32'(rx),
                  32'(model[(int'(a) + k) % DEPTH]));
        end
        check(oe == 1'b1, "R6 oe high in output phase", 32'(oe), 1);
        desel();
        check(oe == 1'b0, "R6 oe low after deselect", 32'(oe), 0);
    endtask

    task automatic t_reset();
        logic [7:0] st;
        check(oe == 1'b0 && wr_req == 1'b0, "R1 outputs idle", {oe, wr_req}, 0);
        read_status(st);
        check(st == 8'h00, "R1 R3 status after reset", 32'(st), 0);
    endtask

    task automatic t_flags();
        logic [7:0] st, rx;
        cmd1(8'h06);
        sel(); xfer(8'h05, rx); xfer(8'h00, st); xfer(8'h00, rx); desel();
        check(st == 8'h02, "R2 flag set", 32'(st), 32'h02);
        check(rx == 8'h02, "R3 status repeats", 32'(rx), 32'h02);
        cmd1(8'h04);
        read_status(st);
        check(st == 8'h00, "R2 flag cleared", 32'(st), 0);
        sel(); bits(7, 8'h06, rx); desel();
        read_status(st);
        check(st == 8'h00, "R2 seven-bit command ignored", 32'(st), 0);
        sel(); xfer(8'h06, rx); bits(4, 8'hF0, rx); desel();
        read_status(st);
        check(st == 8'h00, "R2 stray bits ignored", 32'(st), 0);
    endtask

    task automatic t_read();
        read_check(24'h000005, 4, "R4 R5 read stream");
        read_check(24'(DEPTH - 2), 4, "R5 wrap at top");
        read_check(24'h123441, 2, "R4 address modulo depth");
    endtask

    task automatic t_mode3();
        mode3 = 1'b1;
        read_check(24'h000020, 3, "R10 mode 3 read");
        mode3 = 1'b0;
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_busy();
        logic [7:0] st, rx;
        int r0;
        busy = 1'b1;
        r0 = req_cnt;
        read_status(st);
        check(st == 8'h01, "R3 busy bit", 32'(st), 32'h01);
        oe_seen = 1'b0;
        sel();
        xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h04, rx);
        xfer(8'h00, rx); xfer(8'h00, rx);
        desel();
        check(oe_seen == 1'b0, "R7 refused read no output", 32'(oe_seen), 0);
        check(req_cnt == r0, "R7 no request", req_cnt, r0);
        busy = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_write_req();
        logic [7:0] st, rx;
        int r0;
        r0 = req_cnt;
        sel(); xfer(8'hD8, rx); xfer(8'h00, rx); xfer(8'h01, rx); xfer(8'h23, rx); desel();
        check(req_cnt == r0, "R8 no request without flag", req_cnt, r0);
        cmd1(8'h06);
        sel(); xfer(8'hD8, rx); xfer(8'h00, rx); xfer(8'h01, rx); xfer(8'h23, rx); desel();
        check(req_cnt == r0 + 1 && lk == 2'd1 && la == 24'h000123, "R8 sector request",
              {6'(req_cnt - r0), lk, la}, {6'd1, 2'd1, 24'h000123});
        read_status(st);
        check(st == 8'h00, "R8 flag cleared by request", 32'(st), 0);
        cmd1(8'h06);
        cmd1(8'hC7);
        check(req_cnt == r0 + 2 && lk == 2'd2 && la == 24'd0, "R8 bulk request",
              {6'(req_cnt - r0), lk, la}, {6'd2, 2'd2, 24'd0});
        cmd1(8'h06);
        sel(); xfer(8'h01, rx); xfer(8'h9C, rx); desel();
        check(req_cnt == r0 + 3 && lk == 2'd3 && ld == 8'h9C, "R8 status-write request",
              {6'(req_cnt - r0), lk, ld}, {6'd3, 2'd3, 8'h9C});
        cmd1(8'h06);
        sel(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h30, rx);
        xfer(8'h55, rx); desel();
        check(req_cnt == r0 + 4 && lk == 2'd0 && la == 24'h000030, "R8 page request",
              {6'(req_cnt - r0), lk, la}, {6'd4, 2'd0, 24'h000030});
        busy = 1'b1;
        cmd1(8'h06);
        cmd1(8'hC7);
        check(req_cnt == r0 + 4, "R8 no request while busy", req_cnt, r0 + 4);
        read_status(st);
        check(st == 8'h03, "R8 flag kept when refused", 32'(st), 32'h03);
        busy = 1'b0;
        cmd1(8'h04);
    endtask

    task automatic t_sleep();
        logic [7:0] st, rx;
        cmd1(8'hB9);
        oe_seen = 1'b0;
        read_status(st);
        sel(); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h00, rx);
        xfer(8'h00, rx); desel();
        check(oe_seen == 1'b0, "R9 no output in sleep", 32'(oe_seen), 0);
        cmd1(8'h06);
        cmd1(8'hAB);
        read_status(st);
        check(st == 8'h00, "R9 wake, flag command ignored", 32'(st), 0);
    endtask

    task automatic t_array_write();
        we = 1'b1; waddr = AW'(10); wdata = 8'hC3;
        @(negedge clk);
        we = 1'b0;
        model[10] = 8'hC3;
        read_check(24'h00000A, 1, "R11 written byte");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'(i * 37 + 90);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_flags();
        t_read();
        t_mode3();
        t_busy();
        t_write_req();
        t_sleep();
        t_array_write();
        summary();
    end

endmodule